// File: doc/BRIEF.md
# Translation Lookaside Buffer with Contiguous-Range Entries

This block is a small fully associative translation cache for 4 KB pages. Each entry is filled with a virtual page number, a physical page number, a 4-bit attribute field and a contiguous-hint flag. When coalescing is enabled and a fill carries the hint, the entry covers a 64 KB aligned group of sixteen pages. Virtual page bits [15:12] then drop out of the compare, and the same bits of the lookup address pass through into the physical result.

A lookup presents a 32-bit virtual address and gets back hit, a 40-bit physical address and the attributes one cycle later, all from registers. Two invalidate inputs act on the stored entries. The single-page invalidate clears every entry whose range covers the given page, whether that entry holds one page or a group. The other invalidate clears the whole buffer.

A fill that overlaps resident entries first removes them, so at most one entry ever matches. Replacement looks for invalid slots in round-robin order and only evicts a valid slot when the buffer is full.

Top module: `range_tlb`

## Requirements
- R1: A lookup request that hits a single-page entry raises `lk_hit_o` on the next clock edge. `lk_pa_o` is then {stored ppn, va[11:0]} and `lk_attr_o` is the stored attributes.
- R2: When there is no hit (after reset, on a miss, or when no request is made), `lk_hit_o`, `lk_pa_o` and `lk_attr_o` are all zero on the next cycle.
- R3: With `coalesce_en_i`=1, a fill with `fill_hint_i`=1 matches every virtual address whose bits [31:16] equal fill vpn[19:4]. The result is pa = {fill ppn[27:4], va[15:12], va[11:0]}.
- R4: With `coalesce_en_i`=0 at fill time, a hinted fill is stored as a single page. The filled page returns the same result as it would with coalescing on, and the other pages of its group miss.
- R5: `inv_addr_i` clears every valid entry whose range (one page, or a 64 KB group) contains `inv_vpn_i`. Entries that do not cover that page stay valid.
- R6: `inv_all_i` clears every entry in one cycle.
- R7: A lookup made in the same cycle as `inv_addr_i` or `inv_all_i` returns a miss.
- R8: A fill presented in the same cycle as either invalidate is dropped.
- R9: A fill removes every valid entry whose range overlaps its own range, so a lookup matches at most one entry and returns the newest translation.
- R10: A fill goes to the first invalid slot found searching upward from a round-robin pointer. The pointer then moves to the slot after the one written. With all 8 slots valid, the slot at the pointer is replaced, which means the oldest fill when the buffer was filled in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| coalesce_en_i | input | 1 | Allow hinted fills to be stored as 64 KB groups |
| lk_req_i | input | 1 | Lookup request |
| lk_va_i | input | 32 | Lookup virtual address |
| fill_i | input | 1 | Fill strobe |
| fill_vpn_i | input | 20 | Fill virtual page number |
| fill_ppn_i | input | 28 | Fill physical page number |
| fill_attr_i | input | 4 | Fill attributes |
| fill_hint_i | input | 1 | Contiguous-group hint |
| inv_addr_i | input | 1 | Invalidate entries covering `inv_vpn_i` |
| inv_vpn_i | input | 20 | Virtual page number to invalidate |
| inv_all_i | input | 1 | Invalidate all entries |
| lk_hit_o | output | 1 | Registered hit |
| lk_pa_o | output | 40 | Registered physical address |
| lk_attr_o | output | 4 | Registered attributes |

## Verification
The bench builds the block with its default parameters: eight entries, 32-bit virtual and 40-bit physical addresses, 4 KB pages and sixteen-page groups. Eight entries are few enough that a short run can fill the buffer, force an eviction and then free one slot, which exercises the invalid-first search and the wrap of the round-robin pointer. The group width of four bits lets the same set of page numbers test a group against single pages at its edges, an invalidate that lands inside a group, and each direction of overlap between a fill and a resident entry.

// File: rtl/range_tlb_pkg.sv
package range_tlb_pkg;
  localparam int unsigned VA_W_D    = 32;
  localparam int unsigned PA_W_D    = 40;
  localparam int unsigned PG_W_D    = 12;
  localparam int unsigned GRP_W_D   = 4;
  localparam int unsigned ATTR_W_D  = 4;
  localparam int unsigned ENTRIES_D = 8;

  typedef enum logic [1:0] {
    OP_IDLE,
    OP_FILL,
    OP_INV_ADDR,
    OP_INV_ALL
  } tlb_op_e;
endpackage

// File: rtl/tlb_range_cmp.sv
// Entry vs probe compare; group range if either side is grouped.
module tlb_range_cmp #(
  parameter int unsigned VPN_W = 20,
  parameter int unsigned GRP_W = 4
) (
  input  logic             ent_valid_i,
  input  logic             ent_grp_i,
  input  logic [VPN_W-1:0] ent_vpn_i,
  input  logic             probe_grp_i,
  input  logic [VPN_W-1:0] probe_vpn_i,
  output logic             hit_o
);
  logic hi_eq, lo_eq;
  assign hi_eq = ent_vpn_i[VPN_W-1:GRP_W] == probe_vpn_i[VPN_W-1:GRP_W];
  assign lo_eq = ent_vpn_i[GRP_W-1:0] == probe_vpn_i[GRP_W-1:0];
  assign hit_o = ent_valid_i && hi_eq && (ent_grp_i || probe_grp_i || lo_eq);
endmodule

// File: rtl/tlb_victim_pick.sv
// First free slot searching upward from ptr_i; ptr_i if none free.
module tlb_victim_pick #(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     free_i,
  input  logic [IDX_W-1:0] ptr_i,
  output logic [IDX_W-1:0] idx_o
);
  logic found;
  always_comb begin
    idx_o = ptr_i;
    found = 1'b0;
    for (int k = 0; k < int'(N); k++) begin
      if (!found && free_i[(int'(ptr_i) + k) % int'(N)]) begin
        idx_o = IDX_W'((int'(ptr_i) + k) % int'(N));
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/range_tlb.sv
module range_tlb
  import range_tlb_pkg::*;
#(
  parameter int unsigned VA_W   = VA_W_D,
  parameter int unsigned PA_W   = PA_W_D,
  parameter int unsigned PG_W   = PG_W_D,
  parameter int unsigned GRP_W  = GRP_W_D,
  parameter int unsigned ATTR_W = ATTR_W_D,
  parameter int unsigned N      = ENTRIES_D
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 coalesce_en_i,
  input  logic                 lk_req_i,
  input  logic [VA_W-1:0]      lk_va_i,
  input  logic                 fill_i,
  input  logic [VA_W-PG_W-1:0] fill_vpn_i,
  input  logic [PA_W-PG_W-1:0] fill_ppn_i,
  input  logic [ATTR_W-1:0]    fill_attr_i,
  input  logic                 fill_hint_i,
  input  logic                 inv_addr_i,
  input  logic [VA_W-PG_W-1:0] inv_vpn_i,
  input  logic                 inv_all_i,
  output logic                 lk_hit_o,
  output logic [PA_W-1:0]      lk_pa_o,
  output logic [ATTR_W-1:0]    lk_attr_o
);
  localparam int unsigned VPN_W = VA_W - PG_W;
  localparam int unsigned PPN_W = PA_W - PG_W;
  localparam int unsigned IDX_W = $clog2(N);

  logic [N-1:0]      valid_q, grp_q;
  logic [VPN_W-1:0]  vpn_q  [N];
  logic [PPN_W-1:0]  ppn_q  [N];
  logic [ATTR_W-1:0] attr_q [N];
  logic [IDX_W-1:0]  ptr_q, victim;

  logic [N-1:0] match_lk, match_inv, ovl;
  logic [VPN_W-1:0] lk_vpn;
  logic fill_grp, inv_any;
  tlb_op_e op;

  assign lk_vpn   = lk_va_i[VA_W-1:PG_W];
  assign fill_grp = fill_hint_i & coalesce_en_i;
  assign inv_any  = inv_addr_i | inv_all_i;

  always_comb begin
    if (inv_all_i)       op = OP_INV_ALL;
    else if (inv_addr_i) op = OP_INV_ADDR;
    else if (fill_i)     op = OP_FILL;
    else                 op = OP_IDLE;
  end

  for (genvar e = 0; e < N; e++) begin : g_ent
    tlb_range_cmp #(.VPN_W(VPN_W), .GRP_W(GRP_W)) u_lk (
      .ent_valid_i(valid_q[e]), .ent_grp_i(grp_q[e]), .ent_vpn_i(vpn_q[e]),
      .probe_grp_i(1'b0), .probe_vpn_i(lk_vpn), .hit_o(match_lk[e]));
    tlb_range_cmp #(.VPN_W(VPN_W), .GRP_W(GRP_W)) u_inv (
      .ent_valid_i(valid_q[e]), .ent_grp_i(grp_q[e]), .ent_vpn_i(vpn_q[e]),
      .probe_grp_i(1'b0), .probe_vpn_i(inv_vpn_i), .hit_o(match_inv[e]));
    tlb_range_cmp #(.VPN_W(VPN_W), .GRP_W(GRP_W)) u_ovl (
      .ent_valid_i(valid_q[e]), .ent_grp_i(grp_q[e]), .ent_vpn_i(vpn_q[e]),
      .probe_grp_i(fill_grp), .probe_vpn_i(fill_vpn_i), .hit_o(ovl[e]));
  end

  tlb_victim_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
    .free_i(~valid_q | ovl), .ptr_i(ptr_q), .idx_o(victim));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      grp_q   <= '0;
      ptr_q   <= '0;
      for (int e = 0; e < int'(N); e++) begin
        vpn_q[e]  <= '0;
        ppn_q[e]  <= '0;
        attr_q[e] <= '0;
      end
    end else begin
      unique case (op)
        OP_INV_ALL:  valid_q <= '0;
        OP_INV_ADDR: valid_q <= valid_q & ~match_inv;
        OP_FILL: begin
          valid_q         <= (valid_q & ~ovl) | (N'(1) << victim);
          grp_q[victim]   <= fill_grp;
          vpn_q[victim]   <= fill_vpn_i;
          ppn_q[victim]   <= fill_ppn_i;
          attr_q[victim]  <= fill_attr_i;
          ptr_q <= (victim == IDX_W'(N - 1)) ? '0 : victim + IDX_W'(1);
        end
        default: ;
      endcase
    end
  end

  // Lookup mux: match vector is one-hot by construction of fills.
  logic [PPN_W-1:0]  sel_ppn, pa_ppn;
  logic [ATTR_W-1:0] sel_attr;
  logic              sel_grp, hit_d;
  always_comb begin
    sel_ppn  = '0;
    sel_attr = '0;
    sel_grp  = 1'b0;
    for (int e = 0; e < int'(N); e++) begin
      if (match_lk[e]) begin
        sel_ppn  = sel_ppn | ppn_q[e];
        sel_attr = sel_attr | attr_q[e];
        sel_grp  = sel_grp | grp_q[e];
      end
    end
  end
  assign pa_ppn = sel_grp ? {sel_ppn[PPN_W-1:GRP_W], lk_vpn[GRP_W-1:0]} : sel_ppn;
  assign hit_d  = lk_req_i && (|match_lk) && !inv_any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lk_hit_o  <= 1'b0;
      lk_pa_o   <= '0;
      lk_attr_o <= '0;
    end else begin
      lk_hit_o  <= hit_d;
      lk_pa_o   <= hit_d ? {pa_ppn, lk_va_i[PG_W-1:0]} : '0;
      lk_attr_o <= hit_d ? sel_attr : '0;
    end
  end
endmodule

// File: rtl/range_tlb_chk.sv
module range_tlb_chk #(
  parameter int unsigned N      = 8,
  parameter int unsigned PA_W   = 40,
  parameter int unsigned ATTR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lk_req_i,
  input logic              inv_addr_i,
  input logic              inv_all_i,
  input logic              lk_hit_o,
  input logic [PA_W-1:0]   lk_pa_o,
  input logic [ATTR_W-1:0] lk_attr_o,
  input logic [N-1:0]      valid_q,
  input logic [N-1:0]      match_lk
);
  AST_SINGLE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match_lk)); // R9
  AST_HIT_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> $past(lk_req_i)); // R1
  AST_HIT_NEEDS_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> $past(|valid_q)); // R1
  AST_INV_FORCES_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_req_i && (inv_addr_i || inv_all_i)) |=> !lk_hit_o); // R7
  AST_INV_ALL_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_all_i |=> (valid_q == '0)); // R6
  AST_MISS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_hit_o |-> (lk_pa_o == '0 && lk_attr_o == '0)); // R2
endmodule

bind range_tlb range_tlb_chk #(.N(N), .PA_W(PA_W), .ATTR_W(ATTR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .lk_req_i(lk_req_i), .inv_addr_i(inv_addr_i),
  .inv_all_i(inv_all_i), .lk_hit_o(lk_hit_o), .lk_pa_o(lk_pa_o),
  .lk_attr_o(lk_attr_o), .valid_q(valid_q), .match_lk(match_lk));

// File: tb/sim_range_tlb.sv
`timescale 1ns/1ps
module sim_range_tlb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        coal = 1'b1, req = 1'b0, fill = 1'b0, hint = 1'b0;
  logic        inv_a = 1'b0, inv_all = 1'b0;
  logic [31:0] va = '0;
  logic [19:0] fvpn = '0, ivpn = '0;
  logic [27:0] fppn = '0;
  logic [3:0]  fattr = '0;
  logic        hit;
  logic [39:0] pa;
  logic [3:0]  attr;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  range_tlb u0 (
    .clk_i(clk), .rst_ni(rst_n), .coalesce_en_i(coal), .lk_req_i(req),
    .lk_va_i(va), .fill_i(fill), .fill_vpn_i(fvpn), .fill_ppn_i(fppn),
    .fill_attr_i(fattr), .fill_hint_i(hint), .inv_addr_i(inv_a),
    .inv_vpn_i(ivpn), .inv_all_i(inv_all), .lk_hit_o(hit), .lk_pa_o(pa),
    .lk_attr_o(attr));

  task automatic check(string rq, logic eh, logic [39:0] ep, logic [3:0] ea);
    n_run++;
    if (hit !== eh || pa !== ep || attr !== ea) begin
      n_fail++;
      $display("FAIL %s: hit=%0b pa=%h attr=%h expected hit=%0b pa=%h attr=%h",
               rq, hit, pa, attr, eh, ep, ea);
    end
  endtask

  task automatic do_fill(logic [19:0] v, logic [27:0] p, logic [3:0] a, logic h);
    @(negedge clk);
    fill = 1'b1; fvpn = v; fppn = p; fattr = a; hint = h;
    @(negedge clk);
    fill = 1'b0;
  endtask

  task automatic lookup(logic [31:0] addr);
    @(negedge clk);
    req = 1'b1; va = addr;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic expect_hit(string rq, logic [31:0] addr, logic [27:0] ppn, logic [3:0] a);
    lookup(addr);
    check(rq, 1'b1, {ppn, addr[11:0]}, a);
  endtask

  task automatic expect_miss(string rq, logic [31:0] addr);
    lookup(addr);
    check(rq, 1'b0, '0, '0);
  endtask

  task automatic inv_page(logic [19:0] v);
    @(negedge clk);
    inv_a = 1'b1; ivpn = v;
    @(negedge clk);
    inv_a = 1'b0;
  endtask

  task automatic flush();
    @(negedge clk);
    inv_all = 1'b1;
    @(negedge clk);
    inv_all = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R2 reset", 1'b0, '0, '0);
    @(negedge clk);
    rst_n = 1'b1;
    expect_miss("R2 empty", 32'h0000_0000);
  endtask

  task automatic t_single();
    do_fill(20'h12345, 28'h0ABCDEF, 4'h5, 1'b0);
    expect_hit("R1 single", 32'h1234_5678, 28'h0ABCDEF, 4'h5);
    expect_miss("R2 next page", 32'h1234_6000);
    @(negedge clk);
    check("R2 no request", 1'b0, '0, '0);
  endtask

  task automatic t_group();
    flush();
    do_fill(20'h40013, 28'h1234563, 4'h9, 1'b1);
    expect_hit("R3 group low", 32'h4001_0ABC, 28'h1234560, 4'h9);
    expect_hit("R3 group high", 32'h4001_F004, 28'h123456F, 4'h9);
    expect_hit("R3 group filled page", 32'h4001_3010, 28'h1234563, 4'h9);
    expect_miss("R3 beyond group", 32'h4002_0000);
  endtask

  task automatic t_no_coalesce();
    flush();
    coal = 1'b0;
    do_fill(20'h40013, 28'h1234563, 4'h9, 1'b1);
    coal = 1'b1;
    expect_hit("R4 filled page", 32'h4001_3010, 28'h1234563, 4'h9);
    expect_miss("R4 other page", 32'h4001_0000);
  endtask

  task automatic t_inv_addr();
    flush();
    do_fill(20'h40013, 28'h1234563, 4'h9, 1'b1);
    do_fill(20'h00077, 28'h0000077, 4'h3, 1'b0);
    inv_page(20'h40015);
    expect_miss("R5 group cleared", 32'h4001_3000);
    expect_hit("R5 unrelated kept", 32'h0007_7123, 28'h0000077, 4'h3);
    inv_page(20'h00077);
    expect_miss("R5 single cleared", 32'h0007_7123);
  endtask

  task automatic t_inv_all();
    do_fill(20'h00100, 28'h0000100, 4'h1, 1'b0);
    do_fill(20'h00200, 28'h0000200, 4'h2, 1'b1);
    flush();
    expect_miss("R6 entry a", 32'h0010_0000);
    expect_miss("R6 entry b", 32'h0020_5000);
  endtask

  task automatic t_collide();
    flush();
    do_fill(20'h00300, 28'h0000300, 4'h4, 1'b0);
    @(negedge clk);
    req = 1'b1; va = 32'h0030_0044; inv_a = 1'b1; ivpn = 20'h0AAAA;
    @(negedge clk);
    req = 1'b0; inv_a = 1'b0;
    check("R7 lookup with invalidate", 1'b0, '0, '0);
    expect_hit("R7 entry survives", 32'h0030_0044, 28'h0000300, 4'h4);
    @(negedge clk);
    fill = 1'b1; fvpn = 20'h00400; fppn = 28'h0000400; fattr = 4'h6; hint = 1'b0;
    inv_a = 1'b1; ivpn = 20'h0BBBB;
    @(negedge clk);
    fill = 1'b0; inv_a = 1'b0;
    expect_miss("R8 fill dropped", 32'h0040_0000);
    expect_hit("R8 old entry kept", 32'h0030_0000, 28'h0000300, 4'h4);
    @(negedge clk);
    fill = 1'b1; inv_all = 1'b1;
    @(negedge clk);
    fill = 1'b0; inv_all = 1'b0;
    expect_miss("R8 fill with clear-all", 32'h0040_0000);
  endtask

  task automatic t_overlap();
    flush();
    do_fill(20'h50003, 28'h0000100, 4'h1, 1'b0);
    do_fill(20'h50000, 28'h0002000, 4'h2, 1'b1);
    expect_hit("R9 group replaces page", 32'h5000_3000, 28'h0002003, 4'h2);
    do_fill(20'h50005, 28'h0000300, 4'h3, 1'b0);
    expect_hit("R9 page replaces group", 32'h5000_5ABC, 28'h0000300, 4'h3);
    expect_miss("R9 group gone", 32'h5000_3000);
  endtask

  task automatic t_replace();
    flush();
    for (int i = 0; i < 8; i++) do_fill(20'h60000 + 20'(i), 28'h600 + 28'(i), 4'h7, 1'b0);
    for (int i = 0; i < 8; i++)
      expect_hit("R10 all resident", 32'h6000_0000 + (32'(i) << 12), 28'h600 + 28'(i), 4'h7);
    do_fill(20'h60008, 28'h0000608, 4'h8, 1'b0);
    expect_miss("R10 oldest evicted", 32'h6000_0000);
    expect_hit("R10 second kept", 32'h6000_1000, 28'h0000601, 4'h7);
    expect_hit("R10 new present", 32'h6000_8000, 28'h0000608, 4'h8);
    inv_page(20'h60004);
    do_fill(20'h60009, 28'h0000609, 4'h9, 1'b0);
    expect_hit("R10 invalid slot first", 32'h6000_1000, 28'h0000601, 4'h7);
    expect_hit("R10 refill present", 32'h6000_9000, 28'h0000609, 4'h9);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_single();
    t_group();
    t_no_coalesce();
    t_inv_addr();
    t_inv_all();
    t_collide();
    t_overlap();
    t_replace();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule